// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup with LRU Replacement

This block is the tag, lookup and replacement core of a small cache with two ways per set. A requester presents a block address; the low bits pick the set and the remaining bits form the tag. Both ways of the chosen set are compared at the same time, each with its own comparator. One cycle later the block reports hit or miss and the way used. On a hit it also returns the stored data.

On a miss the block picks a victim way. It takes an invalid way first and the lowest-numbered one when both are invalid. When both ways hold valid blocks, it takes the way that has gone longest without use, tracked by one recency bit per set. It then raises a refill request carrying the missing block address and holds it until the lower level answers with the fill data. That data is installed into the victim way, and the block accepts the next request.

Top module: `setassoc_lru_cache`

## Requirements
- R1: After a synchronous reset every way of every set is invalid and every recency bit is clear. `resp_valid` and `refill_req` read 0, and any block accessed first after reset misses.
- R2: The set is the block address modulo SETS (its low log2(SETS) bits) and the tag is the remaining upper bits. Blocks that fall in different sets never displace one another.
- R3: A hit reports `resp_hit`=1, the matching way on `resp_way`, and on `resp_data` the data that was installed for that block. A hit raises no refill request.
- R4: On a miss, an invalid way is chosen as the victim ahead of any valid way. When both ways are invalid, way 0 is chosen.
- R5: On a miss where both ways are valid, the victim is the way used least recently in that set.
- R6: The recency bit of a set is updated on every hit and every fill, so that it names the way not just touched.
- R7: A request accepted while no refill is pending gives exactly one cycle of `resp_valid`, in the cycle after the request. `resp_valid` is 0 in every other cycle.
- R8: A miss reports the victim on `resp_way` with `resp_hit`=0. In the same cycle it raises `refill_req` with the missed block on `refill_block`, and holds both steady until `fill_valid` is seen. The fill is written into the reported way, and `refill_req` drops in the next cycle.
- R9: With SETS=2, the block sequence 0, 8, 0, 6, 8 from reset gives miss (way 0), miss (way 1), hit (way 0), miss (way 1, evicting 8), miss (way 0, evicting 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_block | input | ADDR_W | Block address to look up |
| resp_valid | output | 1 | Lookup result valid, one cycle after the request |
| resp_hit | output | 1 | 1 on hit, 0 on miss |
| resp_way | output | 1 | Way that hit, or victim way on a miss |
| resp_data | output | DATA_W | Stored data of the hit way |
| refill_req | output | 1 | Refill pending for the missed block |
| refill_block | output | ADDR_W | Block address being refilled |
| fill_valid | input | 1 | Fill data present for the pending refill |
| fill_data | input | DATA_W | Data to install in the victim way |

## Verification
The assertions assume that a requester never raises `req_valid` while `refill_req` is high. They also assume that `fill_valid` arrives only while a refill is pending. The checks on refill stability and response timing hold only under these two conditions. Every bench task drives one request and then waits for the response. After a miss, it answers with a single one-cycle fill and waits for `refill_req` to drop before the next request, so the stimulus never breaks either condition.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic {
    CST_LOOKUP = 1'b0,
    CST_REFILL = 1'b1
  } cache_state_t;
endpackage

// File: rtl/cache_way.sv
// One way: valid flags and tags in flops for a parallel compare,
// data in an array with registered read for block RAM inference.
module cache_way #(
  parameter int SETS   = 2,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              rd_en,
  output logic              match,
  output logic              set_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  assign set_valid = valid_q[lk_set];
  assign match     = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]    <= wr_tag;
      data_mem[wr_set] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= data_mem[lk_set];
  end
endmodule

// File: rtl/lru_bits.sv
// One recency bit per set; the bit names the way to evict next.
module lru_bits #(
  parameter int SETS = 2,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic             old_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             upd_way
);
  logic [SETS-1:0] lru_q;

  assign old_way = lru_q[rd_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (upd_en) begin
      lru_q[upd_set] <= ~upd_way;
    end
  end
endmodule

// File: rtl/victim_pick.sv
// Invalid way first (lowest index), else the least recently used way.
module victim_pick (
  input  logic [1:0] way_valid,
  input  logic       old_way,
  output logic       victim
);
  always_comb begin
    if (!way_valid[0])      victim = 1'b0;
    else if (!way_valid[1]) victim = 1'b1;
    else                    victim = old_way;
  end
endmodule

// File: rtl/setassoc_lru_cache.sv
module setassoc_lru_cache #(
  parameter int ADDR_W = 8,
  parameter int SETS   = 2,
  parameter int DATA_W = 16,
  localparam int WAYS  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_block,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_way,
  output logic [DATA_W-1:0] resp_data,
  output logic              refill_req,
  output logic [ADDR_W-1:0] refill_block,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  import cache_pkg::*;

  cache_state_t state_q;

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic              accept;
  logic              fill_take;
  logic [WAYS-1:0]   match;
  logic [WAYS-1:0]   way_valid;
  logic [DATA_W-1:0] rd_data [WAYS];
  logic              hit;
  logic              hit_way;
  logic              old_way;
  logic              victim;
  logic              pend_way;
  logic [SET_W-1:0]  pend_set;
  logic [TAG_W-1:0]  pend_tag;
  logic              lru_upd;
  logic [SET_W-1:0]  lru_set;
  logic              lru_way;

  assign lk_set    = req_block[SET_W-1:0];
  assign lk_tag    = req_block[ADDR_W-1:SET_W];
  assign accept    = req_valid && (state_q == CST_LOOKUP);
  assign fill_take = fill_valid && (state_q == CST_REFILL);
  assign hit       = |match;
  assign hit_way   = match[1];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .lk_set   (lk_set),
      .lk_tag   (lk_tag),
      .rd_en    (accept),
      .match    (match[w]),
      .set_valid(way_valid[w]),
      .rd_data  (rd_data[w]),
      .wr_en    (fill_take && (pend_way == w[0])),
      .wr_set   (pend_set),
      .wr_tag   (pend_tag),
      .wr_data  (fill_data)
    );
  end

  victim_pick u_pick (
    .way_valid(way_valid),
    .old_way  (old_way),
    .victim   (victim)
  );

  // Hits and fills never coincide: a fill only happens in refill state.
  assign lru_upd = (accept && hit) || fill_take;
  assign lru_set = fill_take ? pend_set : lk_set;
  assign lru_way = fill_take ? pend_way : hit_way;

  lru_bits #(.SETS(SETS)) u_lru (
    .clk    (clk),
    .rst    (rst),
    .rd_set (lk_set),
    .old_way(old_way),
    .upd_en (lru_upd),
    .upd_set(lru_set),
    .upd_way(lru_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= CST_LOOKUP;
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_way     <= 1'b0;
      refill_req   <= 1'b0;
      refill_block <= '0;
      pend_way     <= 1'b0;
      pend_set     <= '0;
      pend_tag     <= '0;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_hit <= hit;
        resp_way <= hit ? hit_way : victim;
        if (!hit) begin
          state_q      <= CST_REFILL;
          refill_req   <= 1'b1;
          refill_block <= req_block;
          pend_way     <= victim;
          pend_set     <= lk_set;
          pend_tag     <= lk_tag;
        end
      end else if (fill_take) begin
        state_q    <= CST_LOOKUP;
        refill_req <= 1'b0;
      end
    end
  end

  assign resp_data = resp_way ? rd_data[1] : rd_data[0];
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              refill_req,
  input logic [ADDR_W-1:0] refill_block,
  input logic              fill_valid
);
  // R7: an accepted request answers in the next cycle
  assert_resp_next_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !refill_req) |=> resp_valid);

  // R7: no response without a request one cycle earlier
  assert_resp_cause_R7: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid));

  // R8: a miss raises the refill request together with the response
  assert_miss_refill_R8: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> refill_req);

  // R8: refill request and address hold until the fill arrives
  assert_refill_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !fill_valid) |=> (refill_req && $stable(refill_block)));

  // R8: the fill ends the refill
  assert_refill_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (refill_req && fill_valid) |=> !refill_req);

  // R3: a hit leaves no refill pending
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !refill_req);

  // R1: the first cycle after reset is idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_valid && !refill_req));
endmodule

bind setassoc_lru_cache cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .refill_req  (refill_req),
  .refill_block(refill_block),
  .fill_valid  (fill_valid)
);

// File: tb/tb_setassoc_lru_cache.sv
module tb_setassoc_lru_cache;
  localparam int ADDR_W = 8;
  localparam int SETS   = 2;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_block = '0;
  logic              resp_valid;
  logic              resp_hit;
  logic              resp_way;
  logic [DATA_W-1:0] resp_data;
  logic              refill_req;
  logic [ADDR_W-1:0] refill_block;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  setassoc_lru_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_block(req_block),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_data(resp_data), .refill_req(refill_req),
    .refill_block(refill_block), .fill_valid(fill_valid),
    .fill_data(fill_data)
  );

  function automatic logic [DATA_W-1:0] pattern(input int blk);
    return DATA_W'(16'hA500 ^ (blk * 37));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "resp_valid after reset", 32'(resp_valid), 0);
    chk("R1", "refill_req after reset", 32'(refill_req), 0);
  endtask

  // One lookup; on a miss, supply the fill and check the refill handshake.
  task automatic access(input int blk, input bit exp_hit, input bit exp_way,
                        input string req);
    req_valid = 1'b1;
    req_block = ADDR_W'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "resp_valid", 32'(resp_valid), 1);
    chk(req, $sformatf("hit for block %0d", blk), 32'(resp_hit), 32'(exp_hit));
    chk(req, $sformatf("way for block %0d", blk), 32'(resp_way), 32'(exp_way));
    if (exp_hit) begin
      chk("R3", "hit data", 32'(resp_data), 32'(pattern(blk)));
      chk("R3", "no refill on hit", 32'(refill_req), 0);
      @(negedge clk);
      chk("R7", "single response pulse", 32'(resp_valid), 0);
    end else begin
      chk("R8", "refill_req on miss", 32'(refill_req), 1);
      chk("R8", "refill_block", 32'(refill_block), 32'(blk));
      @(negedge clk);
      chk("R7", "single response pulse", 32'(resp_valid), 0);
      chk("R8", "refill held", 32'(refill_req), 1);
      fill_valid = 1'b1;
      fill_data  = pattern(blk);
      @(negedge clk);
      fill_valid = 1'b0;
      chk("R8", "refill dropped after fill", 32'(refill_req), 0);
    end
  endtask

  // R9, R4, R5, R6: the classic five-access trace, all in set 0
  task automatic test_trace();
    do_reset();
    access(0, 0, 0, "R9");
    access(8, 0, 1, "R9");
    access(0, 1, 0, "R9");
    access(6, 0, 1, "R9");
    access(8, 0, 0, "R9");
    access(6, 1, 1, "R9");
  endtask

  // R1: contents do not survive a reset
  task automatic test_reset_clears();
    do_reset();
    access(6, 0, 0, "R1");
  endtask

  // R2: set selection by low bits, sets independent
  task automatic test_sets();
    do_reset();
    access(1, 0, 0, "R2");
    access(0, 0, 0, "R2");
    access(1, 1, 0, "R2");
    access(3, 0, 1, "R4");
    access(5, 0, 0, "R5");
    access(0, 1, 0, "R2");
    access(3, 1, 1, "R2");
  endtask

  // R6: hits move the recency bit
  task automatic test_lru_hits();
    do_reset();
    access(2, 0, 0, "R4");
    access(4, 0, 1, "R4");
    access(2, 1, 0, "R6");
    access(4, 1, 1, "R6");
    access(6, 0, 0, "R6");
    access(4, 1, 1, "R6");
    access(2, 0, 0, "R6");
    access(4, 1, 1, "R6");
  endtask

  initial begin
    #800_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_trace();
    test_reset_clears();
    test_sets();
    test_lru_hits();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule